// File: doc/BRIEF.md
# Heartbeat Watchdog Timer

This block watches a software heartbeat line from a processor and raises an active-low alarm when the heartbeat goes quiet for too long. A change of level on the heartbeat line in either direction counts as a kick. Each kick restarts the timeout interval. If no kick arrives within the interval, the alarm output goes low. The expiry also restarts the interval at once, so the timer keeps running.

The heartbeat pin is asynchronous. It passes through a two-flop synchronizer and then a pulse qualifier. The qualifier accepts a new level only after it has been present for a minimum number of clock cycles, so short glitches do not kick the timer. A separate qualifier input tells the block whether a heartbeat source is attached. When it is low, the watchdog is switched off completely. The system reset clears the block.

Every pin here is a plain control or status level. No data stream crosses the block's edge, so there is no valid/ready handshake and no back-pressure. The integrator decides whether to route the alarm back into the reset network. All timing values are in clock cycles: TIMEOUT = TICK_DIV × TICKS.

Top module: `wdt_heartbeat_monitor`

## Requirements
- R1: While `rst_n` is low, `wd_n` is high and the interval count is zero. The synchronizer and the qualified level are cleared to low, so a heartbeat that is high when reset is released counts as a transition.
- R2: Both rising and falling transitions of `hb_in` kick the timer. Suppose a new level is first sampled at clock edge k and then held for MIN_PULSE samples. That transition is accepted at edge k+1+MIN_PULSE, and the interval restarts on that edge.
- R3: If no transition is accepted while `hb_attached` is high, `wd_n` goes low on exactly the TIMEOUT-th clock edge after the last restart.
- R4: A heartbeat whose accepted transitions are TIMEOUT-1 cycles apart never drives `wd_n` low.
- R5: An expiry restarts the interval. `wd_n` stays low through later expiries until a transition is accepted.
- R6: An accepted transition drives `wd_n` high again on the edge where it is accepted.
- R7: A new level that lasts fewer than MIN_PULSE consecutive samples is ignored. It leaves the expiry time unchanged.
- R8: While `hb_attached` is low, `wd_n` is high and the count is held at zero. The first edge at which the qualifier is high again begins a fresh interval.
- R9: When an accepted transition falls on the same edge as an expiry, the transition wins and `wd_n` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset from the system reset |
| hb_in | input | 1 | Asynchronous heartbeat line from the supervised processor |
| hb_attached | input | 1 | High when a heartbeat source is connected; low switches the watchdog off |
| wd_n | output | 1 | Watchdog alarm, low while the timer has expired |

## Verification
The hardest case to reach from the ports is a kick that lands on the same edge as an expiry. It exists only when the heartbeat toggles exactly TIMEOUT cycles apart, after the synchronizer and qualifier latency. The stimulus produces it by toggling at that exact spacing, right after a toggle spaced TIMEOUT-1 apart. Glitches one cycle shorter than the qualifier's minimum width are placed in front of a pending expiry. The random phase varies the toggle density by segment, so both long silences and dense kicking occur.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Width needed to hold values 0..n-1, never less than one bit.
  function automatic int cnt_w(input int n);
    int w;
    w = 1;
    while ((1 << w) < n) w++;
    return w;
  endfunction
endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/wdt_pulse_qual.sv
module wdt_pulse_qual
  import wdt_pkg::*;
#(
  parameter int MIN_PULSE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic s_in,
  output logic kick
);
  localparam int RW = cnt_w(MIN_PULSE);
  localparam logic [RW-1:0] RUN_LAST = RW'(MIN_PULSE - 1);

  logic          level;
  logic [RW-1:0] run;
  logic          differ;

  assign differ = s_in ^ level;
  assign kick   = differ && (run == RUN_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= 1'b0;
      run   <= '0;
    end else begin
      if (!differ || kick) run <= '0;
      else                 run <= run + 1'b1;
      if (kick) level <= s_in;
    end
  end

  AST_LEVEL_ONLY_ON_KICK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level) |-> $past(kick)); // R7

  AST_KICK_ADOPTS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (level == $past(s_in))); // R2
endmodule

// File: rtl/wdt_expiry_timer.sv
module wdt_expiry_timer
  import wdt_pkg::*;
#(
  parameter int TICK_DIV = 4,
  parameter int TICKS    = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic kick,
  output logic wd_n
);
  localparam int TW = cnt_w(TICKS);
  localparam logic [TW-1:0] TICK_LAST = TW'(TICKS - 1);

  logic          clr;
  logic          pre_last;
  logic [TW-1:0] tk;
  logic          expire;

  assign clr = !enable || kick;

  generate
    if (TICK_DIV == 1) begin : g_nodiv
      assign pre_last = 1'b1;
    end else begin : g_div
      localparam int PW = cnt_w(TICK_DIV);
      localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);
      logic [PW-1:0] pre;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                pre <= '0;
        else if (clr || pre_last)  pre <= '0;
        else                       pre <= pre + 1'b1;
      end
      assign pre_last = (pre == PRE_LAST);
    end
  endgenerate

  assign expire = pre_last && (tk == TICK_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tk   <= '0;
      wd_n <= 1'b1;
    end else if (clr) begin
      tk   <= '0;
      wd_n <= 1'b1;
    end else if (expire) begin
      tk   <= '0;
      wd_n <= 1'b0;
    end else if (pre_last) begin
      tk   <= tk + 1'b1;
    end
  end

  AST_DETACH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> wd_n); // R8

  AST_KICK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> wd_n); // R9

  AST_TRIP_NEEDS_SILENCE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wd_n) |-> $past(enable && !kick)); // R3

  AST_LOW_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wd_n && enable && !kick) |=> !wd_n); // R5
endmodule

// File: rtl/wdt_heartbeat_monitor.sv
module wdt_heartbeat_monitor #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PULSE   = 2,
  parameter int TICK_DIV    = 4,
  parameter int TICKS       = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hb_in,
  input  logic hb_attached,
  output logic wd_n
);
  logic hb_s;
  logic kick;

  wdt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (hb_in),
    .q     (hb_s)
  );

  wdt_pulse_qual #(.MIN_PULSE(MIN_PULSE)) u_qual (
    .clk   (clk),
    .rst_n (rst_n),
    .s_in  (hb_s),
    .kick  (kick)
  );

  wdt_expiry_timer #(.TICK_DIV(TICK_DIV), .TICKS(TICKS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (hb_attached),
    .kick   (kick),
    .wd_n   (wd_n)
  );
endmodule

// File: tb/tb_wdt_heartbeat_monitor.sv
module tb_wdt_heartbeat_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int MIN_PULSE  = 2;
  localparam int TICK_DIV   = 4;
  localparam int TICKS      = 25;
  localparam int TIMEOUT    = TICK_DIV * TICKS;
  localparam int MAX_CYCLES = 60000;

  logic clk = 1'b0;
  logic rst_n, hb_in, hb_attached;
  logic wd_n;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  bit done = 0;

  // reference model state, driven by the requirements
  logic m_s1, m_s2, m_lvl, m_wd;
  int   m_run, m_cnt;

  wdt_heartbeat_monitor #(
    .SYNC_STAGES(2), .MIN_PULSE(MIN_PULSE), .TICK_DIV(TICK_DIV), .TICKS(TICKS)
  ) dut (
    .clk(clk), .rst_n(rst_n), .hb_in(hb_in), .hb_attached(hb_attached), .wd_n(wd_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic accepted(input logic s2, input logic lvl, input int run);
    return (s2 != lvl) && (run == MIN_PULSE - 1);
  endfunction

  always @(posedge clk) begin
    logic acc;
    cyc = cyc + 1;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_lvl = 0; m_run = 0; m_cnt = 0; m_wd = 1;
    end else begin
      acc = accepted(m_s2, m_lvl, m_run);
      if (m_s2 == m_lvl || acc) m_run = 0; else m_run = m_run + 1;
      if (acc) m_lvl = m_s2;
      m_s2 = m_s1;
      m_s1 = hb_in;
      if (!hb_attached || acc) begin m_cnt = 0; m_wd = 1; end
      else if (m_cnt == TIMEOUT - 1) begin m_cnt = 0; m_wd = 0; end
      else m_cnt = m_cnt + 1;
    end
    if (cyc > MAX_CYCLES && !done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected <= %0d", cyc, MAX_CYCLES);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic check(input string req);
    vectors++;
    if (wd_n !== m_wd) begin
      miscompares++;
      $display("FAIL %s cycle %0d: wd_n actual %b expected %b", req, cyc, wd_n, m_wd);
    end
  endtask

  task automatic run_cycles(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(req);
    end
  endtask

  initial begin
    int p;
    rst_n = 0; hb_in = 0; hb_attached = 1;
    void'($urandom(32'd20240611));
    run_cycles(5, "R1");
    rst_n = 1;
    run_cycles(3, "R1");
    // both directions, spacing at the limit
    for (int i = 0; i < 6; i++) begin
      hb_in = ~hb_in;
      run_cycles(TIMEOUT - 1, "R2 R4");
    end
    // spacing equal to the timeout: kick coincides with expiry
    for (int i = 0; i < 4; i++) begin
      hb_in = ~hb_in;
      run_cycles(TIMEOUT, "R9");
    end
    // silence: trip at exactly TIMEOUT, stay low across re-expiries
    run_cycles(TIMEOUT + 5, "R3");
    run_cycles(2 * TIMEOUT, "R5");
    hb_in = ~hb_in;
    run_cycles(10, "R6");
    // a pulse shorter than the minimum width must not kick
    run_cycles(TIMEOUT - 20, "R7");
    hb_in = ~hb_in;
    run_cycles(MIN_PULSE - 1, "R7");
    hb_in = ~hb_in;
    run_cycles(30, "R7");
    // detach: quiet and cleared, toggles ignored, fresh interval on reattach
    hb_attached = 0;
    run_cycles(2 * TIMEOUT, "R8");
    hb_in = ~hb_in;
    run_cycles(TIMEOUT + 10, "R8");
    hb_attached = 1;
    run_cycles(TIMEOUT + 10, "R8");
    // reset during an expired state
    rst_n = 0;
    run_cycles(3, "R1");
    hb_in = 1;
    rst_n = 1;
    run_cycles(TIMEOUT + 10, "R1");
    // constrained random, toggle density chosen per segment
    for (int seg = 0; seg < 12; seg++) begin
      case ($urandom % 4)
        0: p = 0;
        1: p = 1;
        2: p = 3;
        default: p = 12;
      endcase
      for (int i = 0; i < 400; i++) begin
        int r;
        r = $urandom % 1000;
        if (r < p * 10) hb_in = ~hb_in;
        else if (r < p * 10 + 4) hb_attached = ~hb_attached;
        else if (r == 999) rst_n = 0;
        else rst_n = 1;
        if (!hb_attached && ($urandom % 50 == 0)) hb_attached = 1;
        run_cycles(1, "R2 R3 R5 R7 R8 random");
      end
    end
    rst_n = 1; hb_attached = 1;
    run_cycles(2 * TIMEOUT, "R3 R5");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule